// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block sits beside the execute stage of a five-stage in-order integer pipeline. For the instruction now executing, it decides where each of its two ALU operands should come from: the value read from the register file during decode, the ALU result held in the EX/MEM pipeline register, or the writeback value held in the MEM/WB pipeline register. The decision is made by comparing the executing instruction's two source register indices with the destination indices and write-enable flags of the two older instructions still in flight.

The selects are combinational and visible on the ports. A thin registered wrapper applies them to two operand multiplexers and captures the chosen operands on the next clock edge, where the ALU would consume them. A same-cycle writeback is already visible to a decode-stage read, because the register file writes early in a cycle and reads late. Only the two bypass paths are needed.

Top module: `fwd_unit_top`

## Requirements
- R1: Each operand select uses the code 2'b00 for the register-file value, 2'b01 for the EX/MEM ALU result and 2'b10 for the MEM/WB writeback value. The code 2'b11 never appears.
- R2: An operand select is 2'b01 when the EX/MEM write flag is high, the EX/MEM destination index is nonzero, and it equals that operand's source index.
- R3: An operand select is 2'b10 when the MEM/WB write flag is high, the MEM/WB destination index is nonzero, it equals that operand's source index, and R2 does not apply.
- R4: When both stages qualify under R2 and R3 for the same source index, the select is 2'b01, so the newer result wins.
- R5: A stage whose write flag is low never causes a forward, even when its destination index matches.
- R6: A destination index of zero never causes a forward, even with its write flag high and a source index of zero. The select stays 2'b00.
- R7: Operand A compares against the rs index and operand B against the rt index. The two selects are computed independently, and both may forward when rs equals rt.
- R8: On each rising clock edge outside reset, each registered operand output takes the value its select chose in the cycle before the edge.
- R9: While synchronous reset is high at a clock edge, both registered operand outputs become zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ex_rs | input | 5 | Source index for operand A of the executing instruction |
| ex_rt | input | 5 | Source index for operand B of the executing instruction |
| rf_val_a | input | 32 | Register-file value read for operand A |
| rf_val_b | input | 32 | Register-file value read for operand B |
| exm_wr | input | 1 | EX/MEM instruction writes a register |
| exm_rd | input | 5 | EX/MEM destination index |
| exm_res | input | 32 | EX/MEM ALU result |
| mwb_wr | input | 1 | MEM/WB instruction writes a register |
| mwb_rd | input | 5 | MEM/WB destination index |
| mwb_res | input | 32 | MEM/WB writeback value |
| sel_a | output | 2 | Operand A source select |
| sel_b | output | 2 | Operand B source select |
| opnd_a | output | 32 | Registered operand A |
| opnd_b | output | 32 | Registered operand B |

## Verification
The bench builds the block with its default 32-bit data width and 5-bit register index, so index 0 and index 31 are both reachable. The bench's register model gives the register file, the EX/MEM result and the MEM/WB value distinct upper nibbles, so a wrong multiplexer leg shows up in the operand value as well as in the select. With only 32 indices, the bench can sweep every pairing of write flag with a zero, matching or unrelated destination in both stages, for both operands at once.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    typedef enum logic [1:0] {
        SEL_RF  = 2'b00,
        SEL_EXM = 2'b01,
        SEL_MWB = 2'b10
    } opsel_e;

    localparam int NUM_OPND = 2;

    function automatic opsel_e pick_src(input logic hit_newer, input logic hit_older);
        if (hit_newer)
            return SEL_EXM;
        else if (hit_older)
            return SEL_MWB;
        return SEL_RF;
    endfunction

endpackage

// File: rtl/fwd_match.sv
module fwd_match
    import fwd_pkg::*;
#(
    parameter int RIDX_W = 5
) (
    input  logic [RIDX_W-1:0] src_idx,
    input  logic              exm_wr,
    input  logic [RIDX_W-1:0] exm_rd,
    input  logic              mwb_wr,
    input  logic [RIDX_W-1:0] mwb_rd,
    output opsel_e            sel
);
    logic exm_hit;
    logic mwb_hit;

    // Index zero is hardwired to zero and is never a bypass target.
    always_comb begin
        exm_hit = exm_wr && (exm_rd != '0) && (exm_rd == src_idx);
        mwb_hit = mwb_wr && (mwb_rd != '0) && (mwb_rd == src_idx);
        sel     = pick_src(exm_hit, mwb_hit);
    end
endmodule

// File: rtl/fwd_opmux.sv
module fwd_opmux
    import fwd_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  opsel_e            sel,
    input  logic [XLEN-1:0]   rf_val,
    input  logic [XLEN-1:0]   exm_val,
    input  logic [XLEN-1:0]   mwb_val,
    output logic [XLEN-1:0]   y
);
    always_comb begin
        unique case (sel)
            SEL_EXM: y = exm_val;
            SEL_MWB: y = mwb_val;
            default: y = rf_val;
        endcase
    end
endmodule

// File: rtl/fwd_unit_top.sv
module fwd_unit_top
    import fwd_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int RIDX_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [RIDX_W-1:0] ex_rs,
    input  logic [RIDX_W-1:0] ex_rt,
    input  logic [XLEN-1:0]   rf_val_a,
    input  logic [XLEN-1:0]   rf_val_b,
    input  logic              exm_wr,
    input  logic [RIDX_W-1:0] exm_rd,
    input  logic [XLEN-1:0]   exm_res,
    input  logic              mwb_wr,
    input  logic [RIDX_W-1:0] mwb_rd,
    input  logic [XLEN-1:0]   mwb_res,
    output logic [1:0]        sel_a,
    output logic [1:0]        sel_b,
    output logic [XLEN-1:0]   opnd_a,
    output logic [XLEN-1:0]   opnd_b
);
    logic [RIDX_W-1:0] src_w  [NUM_OPND];
    logic [XLEN-1:0]   rf_w   [NUM_OPND];
    opsel_e            sel_w  [NUM_OPND];
    logic [XLEN-1:0]   mux_w  [NUM_OPND];
    logic [XLEN-1:0]   opnd_q [NUM_OPND];

    assign src_w[0] = ex_rs;
    assign src_w[1] = ex_rt;
    assign rf_w[0]  = rf_val_a;
    assign rf_w[1]  = rf_val_b;

    for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
        fwd_match #(.RIDX_W(RIDX_W)) u_match (
            .src_idx (src_w[g]),
            .exm_wr  (exm_wr),
            .exm_rd  (exm_rd),
            .mwb_wr  (mwb_wr),
            .mwb_rd  (mwb_rd),
            .sel     (sel_w[g])
        );

        fwd_opmux #(.XLEN(XLEN)) u_mux (
            .sel     (sel_w[g]),
            .rf_val  (rf_w[g]),
            .exm_val (exm_res),
            .mwb_val (mwb_res),
            .y       (mux_w[g])
        );

        always_ff @(posedge clk) begin
            if (rst)
                opnd_q[g] <= '0;
            else
                opnd_q[g] <= mux_w[g];
        end
    end

    assign sel_a  = sel_w[0];
    assign sel_b  = sel_w[1];
    assign opnd_a = opnd_q[0];
    assign opnd_b = opnd_q[1];
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
    parameter int XLEN   = 32,
    parameter int RIDX_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic [RIDX_W-1:0] ex_rs,
    input logic [RIDX_W-1:0] ex_rt,
    input logic [XLEN-1:0]   rf_val_a,
    input logic              exm_wr,
    input logic [RIDX_W-1:0] exm_rd,
    input logic [XLEN-1:0]   exm_res,
    input logic              mwb_wr,
    input logic [RIDX_W-1:0] mwb_rd,
    input logic [XLEN-1:0]   mwb_res,
    input logic [1:0]        sel_a,
    input logic [1:0]        sel_b,
    input logic [XLEN-1:0]   opnd_a
);
    a_r1_code_legal: assert property (@(posedge clk) disable iff (rst)
        (sel_a != 2'b11) && (sel_b != 2'b11));

    a_r4_newer_wins: assert property (@(posedge clk) disable iff (rst)
        (exm_wr && exm_rd != '0 && exm_rd == ex_rs) |-> (sel_a == 2'b01));

    a_r5_no_write_no_fwd: assert property (@(posedge clk) disable iff (rst)
        (!exm_wr && !mwb_wr) |-> (sel_a == 2'b00 && sel_b == 2'b00));

    a_r6_zero_never_fwd: assert property (@(posedge clk) disable iff (rst)
        (ex_rt == '0) |-> (sel_b == 2'b00));

    a_r8_exm_captured: assert property (@(posedge clk) disable iff (rst)
        (sel_a == 2'b01) |=> (opnd_a == $past(exm_res)));

    a_r8_mwb_captured: assert property (@(posedge clk) disable iff (rst)
        (sel_a == 2'b10) |=> (opnd_a == $past(mwb_res)));

    a_r8_rf_captured: assert property (@(posedge clk) disable iff (rst)
        (sel_a == 2'b00) |=> (opnd_a == $past(rf_val_a)));
endmodule

bind fwd_unit_top fwd_unit_chk #(.XLEN(XLEN), .RIDX_W(RIDX_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ex_rs    (ex_rs),
    .ex_rt    (ex_rt),
    .rf_val_a (rf_val_a),
    .exm_wr   (exm_wr),
    .exm_rd   (exm_rd),
    .exm_res  (exm_res),
    .mwb_wr   (mwb_wr),
    .mwb_rd   (mwb_rd),
    .mwb_res  (mwb_res),
    .sel_a    (sel_a),
    .sel_b    (sel_b),
    .opnd_a   (opnd_a)
);

// File: tb/sim_fwd_unit_top.sv
module sim_fwd_unit_top;
    localparam int XLEN   = 32;
    localparam int RIDX_W = 5;

    logic              clk = 1'b0;
    logic              rst;
    logic [RIDX_W-1:0] ex_rs, ex_rt, exm_rd, mwb_rd;
    logic              exm_wr, mwb_wr;
    logic [XLEN-1:0]   rf_val_a, rf_val_b, exm_res, mwb_res;
    logic [1:0]        sel_a, sel_b;
    logic [XLEN-1:0]   opnd_a, opnd_b;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    fwd_unit_top #(.XLEN(XLEN), .RIDX_W(RIDX_W)) u0 (
        .clk(clk), .rst(rst), .ex_rs(ex_rs), .ex_rt(ex_rt),
        .rf_val_a(rf_val_a), .rf_val_b(rf_val_b),
        .exm_wr(exm_wr), .exm_rd(exm_rd), .exm_res(exm_res),
        .mwb_wr(mwb_wr), .mwb_rd(mwb_rd), .mwb_res(mwb_res),
        .sel_a(sel_a), .sel_b(sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b)
    );

    // Vector: rs, rt, exm_wr, exm_rd, mwb_wr, mwb_rd, expected sel_a, expected sel_b
    localparam int VW = 26;
    localparam logic [VW-1:0] VEC [10] = '{
        {5'd3,  5'd4,  1'b1, 5'd3,  1'b0, 5'd0,  2'b01, 2'b00},  // R2
        {5'd3,  5'd4,  1'b0, 5'd0,  1'b1, 5'd4,  2'b00, 2'b10},  // R3
        {5'd9,  5'd9,  1'b1, 5'd9,  1'b1, 5'd9,  2'b01, 2'b01},  // R4 R7
        {5'd9,  5'd2,  1'b0, 5'd9,  1'b1, 5'd9,  2'b10, 2'b00},  // R5
        {5'd9,  5'd2,  1'b0, 5'd9,  1'b0, 5'd2,  2'b00, 2'b00},  // R5
        {5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 5'd0,  2'b00, 2'b00},  // R6
        {5'd31, 5'd1,  1'b1, 5'd1,  1'b1, 5'd31, 2'b10, 2'b01},  // R7
        {5'd5,  5'd6,  1'b1, 5'd6,  1'b1, 5'd5,  2'b10, 2'b01},  // R7
        {5'd31, 5'd31, 1'b1, 5'd30, 1'b1, 5'd31, 2'b10, 2'b10},  // R3 R7
        {5'd8,  5'd8,  1'b1, 5'd7,  1'b1, 5'd6,  2'b00, 2'b00}   // R1
    };

    function automatic logic [1:0] ref_sel(input logic [4:0] s, input logic ew,
                                           input logic [4:0] er, input logic mw,
                                           input logic [4:0] mr);
        if (ew && er == s && s != 0) return 2'b01;
        if (mw && mr == s && s != 0) return 2'b10;
        return 2'b00;
    endfunction

    function automatic string tag_of(input logic [4:0] s, input logic ew,
                                     input logic [4:0] er, input logic mw,
                                     input logic [4:0] mr);
        bit he = ew && er == s && s != 0;
        bit hm = mw && mr == s && s != 0;
        if (he && hm) return "R4";
        if (he) return "R2";
        if (hm) return "R3";
        if (s == 0 && (er == 0 || mr == 0)) return "R6";
        if ((er == s && !ew) || (mr == s && !mw)) return "R5";
        return "R1";
    endfunction

    function automatic logic [XLEN-1:0] pick_val(input logic [1:0] sl,
                                                 input logic [XLEN-1:0] rf);
        if (sl == 2'b01) return exm_res;
        if (sl == 2'b10) return mwb_res;
        return rf;
    endfunction

    task automatic check(input string req, input logic [XLEN-1:0] act,
                         input logic [XLEN-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one case at the falling edge, check selects, then the registered operands.
    task automatic apply(input logic [4:0] rs, input logic [4:0] rt, input logic ew,
                         input logic [4:0] er, input logic mw, input logic [4:0] mr,
                         input logic [1:0] xa, input logic [1:0] xb, input string ta,
                         input string tb);
        logic [XLEN-1:0] va, vb;
        @(negedge clk);
        ex_rs = rs; ex_rt = rt; exm_wr = ew; exm_rd = er; mwb_wr = mw; mwb_rd = mr;
        rf_val_a = 32'hA000_0000 | {27'd0, rs};
        rf_val_b = 32'hB000_0000 | {27'd0, rt};
        exm_res  = 32'hE000_0100 | {27'd0, er};
        mwb_res  = 32'hD000_0200 | {27'd0, mr};
        #2;
        check(ta, {30'd0, sel_a}, {30'd0, xa});
        check(tb, {30'd0, sel_b}, {30'd0, xb});
        va = pick_val(xa, rf_val_a);
        vb = pick_val(xb, rf_val_b);
        @(posedge clk);
        #1;
        check("R8", opnd_a, va);
        check("R8", opnd_b, vb);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [4:0] rdset [4];
        rdset[0] = 5'd0; rdset[1] = 5'd7; rdset[2] = 5'd12; rdset[3] = 5'd20;
        rst = 1'b1;
        ex_rs = 5'd7; ex_rt = 5'd7; exm_wr = 1'b1; exm_rd = 5'd7; mwb_wr = 1'b0; mwb_rd = 5'd0;
        rf_val_a = '1; rf_val_b = '1; exm_res = '1; mwb_res = '1;
        repeat (3) @(posedge clk);
        #1;
        check("R9", opnd_a, '0);
        check("R9", opnd_b, '0);
        @(negedge clk);
        rst = 1'b0;

        // Table walk
        for (int i = 0; i < 10; i++) begin
            logic [VW-1:0] v = VEC[i];
            apply(v[25:21], v[20:16], v[15], v[14:10], v[9], v[8:4], v[3:2], v[1:0],
                  "R7 opA", "R7 opB");
        end

        // Exhaustive sweep: operand A uses rs=7, operand B uses rt=12
        for (int ew = 0; ew < 2; ew++)
            for (int mw = 0; mw < 2; mw++)
                for (int ei = 0; ei < 4; ei++)
                    for (int mi = 0; mi < 4; mi++)
                        apply(5'd7, 5'd12, ew[0], rdset[ei], mw[0], rdset[mi],
                              ref_sel(5'd7, ew[0], rdset[ei], mw[0], rdset[mi]),
                              ref_sel(5'd12, ew[0], rdset[ei], mw[0], rdset[mi]),
                              tag_of(5'd7, ew[0], rdset[ei], mw[0], rdset[mi]),
                              tag_of(5'd12, ew[0], rdset[ei], mw[0], rdset[mi]));

        // Source index zero against every flag pairing with a zero destination
        for (int f = 0; f < 4; f++)
            apply(5'd0, 5'd0, f[0], 5'd0, f[1], 5'd0, 2'b00, 2'b00, "R6", "R6");

        // Reset mid-stream clears the captured operands
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R9", opnd_a, '0);
        check("R9", opnd_b, '0);
        @(negedge clk);
        rst = 1'b0;

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule